// File: doc/BRIEF.md
# Multiplexed-Bus Machine Cycle Sequencer

This block sequences the external bus of a small 8-bit processor whose 16-bit address space is reached over a high address byte plus a shared low address/data byte. For each request it runs one or more machine cycles as a chain of single-clock T-states. It pulses an address latch enable in the first T-state so that an external latch can hold the low address byte. It then gives the shared byte to the data phase: memory drives it for a read, and the block drives it for a write. One read strobe and one write strobe serve both memory and I/O space, and a separate select line tells the two spaces apart.

The decode logic outside the block supplies a cycle kind and, for instruction fetches, a byte count of 1 to 3. A fetch runs an opcode fetch cycle of four T-states. The remaining bytes follow as plain memory reads from consecutive addresses, low operand byte first. The program counter held in the block advances once per fetched byte. A READY input stretches any cycle by whole wait states, and during a wait state every bus output holds its value. Each byte read is handed to the core on a one-clock valid strobe, together with its position in the instruction.

Top module: `mbus_cycle_seq`

## Requirements
- R1: After reset the block is idle: `busy`=0, `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `byte_valid`=0, and `pc` equals the RESET_PC parameter.
- R2: In the first T-state of every machine cycle `ale` is 1 for exactly one clock, `ad_out` carries the low address byte with `ad_oe`=1, `addr_hi` carries the high address byte, and both strobes are inactive.
- R3: With READY high, an opcode fetch cycle lasts 4 T-states, and a memory or I/O read or write cycle lasts 3 T-states.
- R4: A fetch request with `req_len`=n (0 is taken as 1) runs one opcode fetch at `pc`, then n-1 memory reads at the following addresses in ascending order, with 16-bit wrap. The bytes carry `byte_idx` 0..n-1, and `pc` ends n higher.
- R5: READY is sampled at the end of T2 and at the end of each wait state. Each sample that finds it low adds one clock. During a wait state `addr_hi`, `io_m`, `ad_oe`, `ad_out` and both strobes keep the values they had in T2.
- R6: `req_kind` codes are 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read and 4 I/O write. Reads of either space use `rd_n` and writes use `wr_n`, each low from T2 through T3. `io_m` is 1 for the whole of an I/O cycle and 0 otherwise.
- R7: In a read cycle `ad_oe` is 0 from T2 to the end of the cycle. The byte on `ad_in` at the end of T3 appears on `byte_data`, with `byte_valid` high for one clock.
- R8: In a write cycle `ad_out` equals `req_wdata` with `ad_oe`=1 from T2 through T3, and no `byte_valid` is produced.
- R9: Memory and I/O data cycles leave `pc` unchanged.
- R10: A request made while `busy` is 1 is ignored, and a `req_kind` code of 5 to 7 starts no cycle.
- R11: `pc_ld` loads `pc_ld_val` into `pc` when the block is idle and `req_valid` is 0. It has no effect while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_kind | input | 3 | Cycle kind (see R6) |
| req_len | input | 2 | Instruction length in bytes for a fetch |
| req_addr | input | ADDR_W | Address for data cycles |
| req_wdata | input | DATA_W | Write data |
| pc_ld | input | 1 | Load program counter |
| pc_ld_val | input | ADDR_W | Value to load |
| ready | input | 1 | Low requests wait states |
| busy | output | 1 | A request is in progress |
| addr_hi | output | ADDR_W-DATA_W | High address byte |
| ad_out | output | DATA_W | Shared bus, driven value |
| ad_oe | output | 1 | Shared bus driver enable |
| ad_in | input | DATA_W | Shared bus, received value |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 for I/O space, 0 for memory |
| byte_valid | output | 1 | A read byte is presented |
| byte_data | output | DATA_W | Byte read |
| byte_idx | output | 2 | Byte position within the instruction |
| pc | output | ADDR_W | Program counter |

## Verification
The bench builds the block with the default 16-bit address and 8-bit data widths and sets RESET_PC to 16'h0FFD. With that start, the second instruction's operand bytes carry across into a new high address byte, which brings the carry path of the counter and the `addr_hi` update between cycles within reach. A later load of 16'hFFFF then shows the counter wrapping to zero in the middle of an instruction. Wait-state counts of 0 to 4 are applied per request, so single and repeated READY samples are both exercised.

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [2:0]               req_kind,
  input  logic [1:0]               req_len,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     pc_ld,
  input  logic [ADDR_W-1:0]        pc_ld_val,
  input  logic                     ready,
  output logic                     busy,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     io_m,
  output logic                     byte_valid,
  output logic [DATA_W-1:0]        byte_data,
  output logic [1:0]               byte_idx,
  output logic [ADDR_W-1:0]        pc
);

  localparam logic [2:0] K_FETCH = 3'd0;
  localparam logic [2:0] K_MWR   = 3'd2;
  localparam logic [2:0] K_IORD  = 3'd3;
  localparam logic [2:0] K_IOWR  = 3'd4;
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_TW, S_T3, S_T4} tstate_e;

  tstate_e             st;
  logic [ADDR_W-1:0]   cyc_addr;
  logic                cyc_io, cyc_wr, cyc_op, cyc_ins;
  logic [1:0]          left, idx;
  logic [DATA_W-1:0]   wd_q;
  logic                accept, strobe, chain;
  logic [ADDR_W-1:0]   nxt_addr;

  assign accept   = (st == S_IDLE) && req_valid && (req_kind <= K_IOWR);
  assign strobe   = (st == S_T2) || (st == S_TW) || (st == S_T3);
  assign nxt_addr = (st == S_T3) ? pc + PC_STEP : pc;
  assign chain    = (left != 2'd0);

  assign busy    = (st != S_IDLE);
  assign ale     = (st == S_T1);
  assign rd_n    = !(strobe && !cyc_wr);
  assign wr_n    = !(strobe && cyc_wr);
  assign ad_oe   = (st == S_T1) || (strobe && cyc_wr);
  assign ad_out  = (st == S_T1) ? cyc_addr[DATA_W-1:0] : wd_q;
  assign addr_hi = cyc_addr[ADDR_W-1:DATA_W];
  assign io_m    = cyc_io;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cyc_addr   <= '0;
      cyc_io     <= 1'b0;
      cyc_wr     <= 1'b0;
      cyc_op     <= 1'b0;
      cyc_ins    <= 1'b0;
      left       <= 2'd0;
      idx        <= 2'd0;
      wd_q       <= '0;
      pc         <= RESET_PC;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      byte_idx   <= 2'd0;
    end else begin
      byte_valid <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (accept) begin
            st       <= S_T1;
            cyc_op   <= (req_kind == K_FETCH);
            cyc_ins  <= (req_kind == K_FETCH);
            cyc_io   <= (req_kind == K_IORD) || (req_kind == K_IOWR);
            cyc_wr   <= (req_kind == K_MWR) || (req_kind == K_IOWR);
            cyc_addr <= (req_kind == K_FETCH) ? pc : req_addr;
            left     <= (req_kind == K_FETCH && req_len != 2'd0) ? req_len - 2'd1 : 2'd0;
            idx      <= 2'd0;
            wd_q     <= req_wdata;
          end else if (pc_ld && !req_valid) begin
            pc <= pc_ld_val;
          end
        end
        S_T1: st <= S_T2;
        S_T2, S_TW: st <= ready ? S_T3 : S_TW;
        S_T3, S_T4: begin
          if (st == S_T3) begin
            if (!cyc_wr) begin
              byte_valid <= 1'b1;
              byte_data  <= ad_in;
              byte_idx   <= idx;
            end
            if (cyc_ins) pc <= pc + PC_STEP;
          end
          if (st == S_T3 && cyc_op) begin
            st <= S_T4;
          end else if (chain) begin
            st       <= S_T1;
            cyc_addr <= nxt_addr;
            cyc_op   <= 1'b0;
            left     <= left - 2'd1;
            idx      <= idx + 2'd1;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R3
  fetch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T3 && cyc_op) |=> (st == S_T4 && rd_n && !ale));

  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T3 && cyc_ins) |=> (pc == $past(pc) + PC_STEP));

  // R5
  wait_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_T2 || st == S_TW) && !ready) |=> (st == S_TW && $stable(rd_n) && $stable(wr_n)));

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TW) |-> ($stable(addr_hi) && $stable(ad_oe) && $stable(ad_out) && $stable(io_m)));

  // R7
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R8
  write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (ad_oe && rd_n));

  // R7
  byte_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(!rd_n));

endmodule

// File: tb/mbus_cycle_seq_tb_top.sv
module mbus_cycle_seq_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_kind = 3'd0;
  logic [1:0] req_len = 2'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0] req_wdata = 8'h0;
  logic pc_ld = 1'b0;
  logic [15:0] pc_ld_val = 16'h0;
  logic ready = 1'b1;
  logic busy, ad_oe, ale, rd_n, wr_n, io_m, byte_valid;
  logic [7:0] addr_hi, ad_out, ad_in, byte_data;
  logic [1:0] byte_idx;
  logic [15:0] pc;

  mbus_cycle_seq #(.ADDR_W(16), .DATA_W(8), .RESET_PC(16'h0FFD)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_len(req_len), .req_addr(req_addr), .req_wdata(req_wdata),
    .pc_ld(pc_ld), .pc_ld_val(pc_ld_val), .ready(ready), .busy(busy),
    .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_idx(byte_idx), .pc(pc));

  int checks = 0;
  int errors = 0;
  int nwait = 0;
  logic [15:0] exp_pc = 16'h0FFD;

  typedef struct packed {
    logic [15:0] a; logic io; logic wr; logic op; logic [7:0] nw; logic [7:0] wd;
  } cyc_t;
  typedef struct packed { logic [7:0] d; logic [1:0] i; } byt_t;
  cyc_t cq[$];
  byt_t bq[$];

  function automatic logic [7:0] memf(input logic [15:0] a, input logic io);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ (io ? 8'hC3 : 8'h5A);
  endfunction

  logic [15:0] lat_a = 16'h0;
  logic lat_io = 1'b0;
  assign ad_in = rd_n ? 8'h00 : memf(lat_a, lat_io);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // READY model and address latch
  int wcyc = 0;
  always @(negedge clk) begin
    if (ale) begin
      wcyc = 0;
      lat_a = {addr_hi, ad_out};
      lat_io = io_m;
    end else begin
      wcyc = wcyc + 1;
    end
    ready = (wcyc > nwait);
  end

  // monitor
  bit open = 0;
  int pos, rd_cnt, wr_cnt, s_first, s_last, s_cnt;
  logic [15:0] r_addr;
  logic [7:0] r_hi, wd_seen;
  logic r_io;
  bit t1_bad, oe_bad, wd_bad, hi_bad;

  task automatic close_rec;
    cyc_t e;
    int exp_len;
    open = 0;
    if (cq.size() == 0) begin
      chk(0, "R10 unexpected machine cycle", r_addr, 0);
      return;
    end
    e = cq.pop_front();
    exp_len = (e.op ? 4 : 3) + int'(e.nw);
    chk(pos == exp_len, "R3 R5 cycle length", pos, exp_len);
    chk(r_addr == e.a, "R2 R4 cycle address", r_addr, e.a);
    chk(!t1_bad, "R2 first T-state", t1_bad, 0);
    chk(r_io == e.io && !hi_bad, "R5 R6 io_m/addr_hi held", {r_io, hi_bad}, {e.io, 1'b0});
    if (e.wr) begin
      chk(wr_cnt == int'(e.nw) + 2 && rd_cnt == 0, "R6 R8 write strobe", wr_cnt, int'(e.nw) + 2);
      chk(!wd_bad && wd_seen == e.wd, "R8 write data", wd_seen, e.wd);
    end else begin
      chk(rd_cnt == int'(e.nw) + 2 && wr_cnt == 0, "R6 read strobe", rd_cnt, int'(e.nw) + 2);
    end
    chk(s_first == 2 && s_last == s_first + s_cnt - 1, "R5 strobe position", s_first, 2);
    chk(!oe_bad, "R7 bus release", oe_bad, 0);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid) begin
        if (bq.size() == 0) chk(0, "R8 unexpected byte", byte_data, 0);
        else begin
          byt_t b;
          b = bq.pop_front();
          chk(byte_data == b.d && byte_idx == b.i, "R7 R4 read byte", {byte_idx, byte_data}, {b.i, b.d});
        end
      end
      if (open && (ale || !busy)) close_rec();
      if (ale) begin
        open = 1; pos = 1; rd_cnt = 0; wr_cnt = 0; s_first = 0; s_last = 0; s_cnt = 0;
        r_addr = {addr_hi, ad_out}; r_hi = addr_hi; r_io = io_m;
        t1_bad = !ad_oe || !rd_n || !wr_n;
        oe_bad = 0; wd_bad = 0; hi_bad = 0; wd_seen = 8'h00;
      end else if (open) begin
        pos++;
        if (!rd_n || !wr_n) begin
          s_cnt++;
          if (s_first == 0) s_first = pos;
          s_last = pos;
        end
        if (!rd_n) rd_cnt++;
        if (!wr_n) begin
          if (wr_cnt == 0) wd_seen = ad_out;
          else if (ad_out != wd_seen) wd_bad = 1;
          if (!ad_oe) wd_bad = 1;
          wr_cnt++;
        end
        if (ad_oe && wr_n) oe_bad = 1;
        if (addr_hi != r_hi || io_m != r_io) hi_bad = 1;
      end
    end
  end

  task automatic issue(input logic [2:0] k, input logic [1:0] n, input logic [15:0] a, input logic [7:0] wd);
    @(negedge clk);
    req_valid = 1; req_kind = k; req_len = n; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    while (busy) @(negedge clk);
  endtask

  task automatic push_fetch(input int n, input int nw);
    int cnt;
    cnt = (n == 0) ? 1 : n;
    for (int k = 0; k < cnt; k++) begin
      logic [15:0] a;
      a = exp_pc + 16'(k);
      cq.push_back('{a: a, io: 1'b0, wr: 1'b0, op: (k == 0), nw: 8'(nw), wd: 8'h00});
      bq.push_back('{d: memf(a, 1'b0), i: 2'(k)});
    end
  endtask

  task automatic do_fetch(input int n, input int nw);
    int cnt;
    cnt = (n == 0) ? 1 : n;
    push_fetch(n, nw);
    nwait = nw;
    issue(3'd0, 2'(n), 16'h0, 8'h00);
    chk(pc == exp_pc + 16'(cnt), "R4 pc after fetch", pc, exp_pc + 16'(cnt));
    exp_pc = exp_pc + 16'(cnt);
  endtask

  task automatic do_data(input logic [2:0] k, input logic [15:0] a, input logic [7:0] wd, input int nw);
    logic io, wr;
    io = (k == 3'd3) || (k == 3'd4);
    wr = (k == 3'd2) || (k == 3'd4);
    cq.push_back('{a: a, io: io, wr: wr, op: 1'b0, nw: 8'(nw), wd: wd});
    if (!wr) bq.push_back('{d: memf(a, io), i: 2'd0});
    nwait = nw;
    issue(k, 2'd0, a, wd);
    chk(pc == exp_pc, "R9 pc unchanged", pc, exp_pc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(!busy && !ale && rd_n && wr_n && !ad_oe && !byte_valid, "R1 idle outputs",
        {busy, ale, rd_n, wr_n, ad_oe, byte_valid}, 6'b001100);
    chk(pc == 16'h0FFD, "R1 reset pc", pc, 16'h0FFD);

    do_fetch(1, 0);
    do_fetch(3, 0);
    do_fetch(2, 2);
    do_data(3'd1, 16'h2345, 8'h00, 0);
    do_data(3'd2, 16'h3456, 8'hA5, 1);
    do_data(3'd3, 16'h0042, 8'h00, 3);
    do_data(3'd4, 16'h0081, 8'h3C, 0);
    do_fetch(0, 1);

    // R11 load while idle, then wrap across 16'hFFFF
    @(negedge clk);
    pc_ld = 1; pc_ld_val = 16'hFFFF;
    @(negedge clk);
    pc_ld = 0;
    chk(pc == 16'hFFFF, "R11 pc load", pc, 16'hFFFF);
    exp_pc = 16'hFFFF;
    do_fetch(2, 0);

    // R10 R11 requests and loads while busy are ignored
    push_fetch(3, 1);
    nwait = 1;
    @(negedge clk);
    req_valid = 1; req_kind = 3'd0; req_len = 2'd3;
    @(negedge clk);
    req_valid = 0;
    repeat (2) @(negedge clk);
    req_valid = 1; req_kind = 3'd2; req_addr = 16'h5555; req_wdata = 8'hEE;
    pc_ld = 1; pc_ld_val = 16'h1234;
    @(negedge clk);
    req_valid = 0; pc_ld = 0;
    while (busy) @(negedge clk);
    chk(pc == exp_pc + 16'd3, "R10 R11 pc after busy intrusion", pc, exp_pc + 16'd3);
    exp_pc = exp_pc + 16'd3;

    // R10 reserved kind code
    issue(3'd6, 2'd0, 16'h7777, 8'h11);
    repeat (4) @(negedge clk);
    chk(!busy && cq.size() == 0, "R10 reserved kind", busy, 0);

    do_fetch(3, 4);
    do_data(3'd1, 16'hFFFF, 8'h00, 2);

    repeat (4) @(negedge clk);
    chk(cq.size() == 0, "R3 all cycles seen", cq.size(), 0);
    chk(bq.size() == 0, "R7 all bytes seen", bq.size(), 0);
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R3 watchdog: actual=hung expected=done");
    finish_up();
  end
endmodule